// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear/Toggle and Event Flags

This block is a general-purpose I/O port of up to 32 pins that sits behind a plain word-addressed register bus. Software drives pin levels either by writing the whole output word or through three write-only strobe registers. These set, clear or invert only the bits selected by a mask, so one pin can change without a read-modify-write that could race with another agent. A direction register picks, pin by pin, whether the pad driver is enabled.

Pin levels pass through a two-flop synchroniser. The synchronised value is visible in an input register and feeds a per-pin event detector. Each pin has a two-bit event mode and a DMA-select bit. A detected event latches a sticky flag, and the OR of all flags is the interrupt line. Software clears a flag by writing one to its position. A pin routed to DMA raises a request while its flag is set, and the flag is cleared by that pin's transfer-done strobe. A level-mode condition that is still active sets its flag again in the same cycle it is cleared.

The bus is one write strobe, a 4-bit word index, write data and combinational read data. Word map: 0 output data, 1 set, 2 clear, 3 toggle, 4 direction, 5 input data, 6 event flags, 7 event mode for pins 0-15, 8 event mode for pins 16-31, 9 DMA select. Any other index ignores writes and reads zero.

Top module: `gpio_atomic_port`

## Requirements
- R1: Word 4 holds the direction. Bit n at 1 makes pin n an output (pin_oe[n]=1); at 0 the pin is an input. After reset every pin is an input and every register reads zero.
- R2: A write to word 0 loads the whole output word, and pin_out follows it on the next cycle whatever the direction.
- R3: A write to word 1 forces to 1 every output bit whose mask bit is 1 and leaves the others unchanged.
- R4: A write to word 2 forces to 0 every output bit whose mask bit is 1 and leaves the others unchanged.
- R5: A write to word 3 inverts every output bit whose mask bit is 1 and leaves the others unchanged.
- R6: Words 1, 2 and 3 always read back as zero.
- R7: Word 5 returns the pin levels after two flops: a pin change applied before clock edge k is readable after edge k+1 and not after edge k.
- R8: Word 7 holds pins 0-15 and word 8 holds pins 16-31, two bits per pin at bits 2m+1:2m, where m is the pin number minus 16 for word 8. The codes are 0 off, 1 rising edge, 2 falling edge, 3 high level, all judged on the synchronised input. The flag sets at the edge after the synchronised value shows the condition, which is the third edge after the pin changes.
- R9: Word 6 reads the flags, one bit per pin (0x00020001 means pins 0 and 17 are pending). A flag stays set until a 1 is written to its bit; writing 0 has no effect. evt_irq is 1 when any flag is set.
- R10: A pin in high-level mode whose synchronised input is still 1 keeps its flag set through a write-one clear.
- R11: Word 9 selects DMA per pin. dma_req[n] is flag n while bit n is 1. dma_done[n] clears flag n only when bit n is 1 and is ignored otherwise.
- R12: When an event sets a flag in the same cycle as a clear by write or by dma_done, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output data to pads |
| pin_oe | output | NUM_PINS | Pad driver enable, 1 = output |
| dma_done | input | NUM_PINS | Per-pin DMA transfer-complete strobe |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| evt_irq | output | 1 | OR of all event flags |

## Verification
The bench drives set, clear and toggle masks that overlap bits already at 1 and at 0. A design that rewrote the whole word, or ignored the mask, would disturb bits outside the mask. It counts edges from a pin change to the input register and to the flag, so a synchroniser that is one flop short or long shows up at once. Level mode is cleared while the input stays high, where a design that let the clear win would drop the flag. The bench fires dma_done both on a pin not routed to DMA and in the same cycle as a new edge event. It catches a strobe that is not gated by the select bit and a clear that takes priority over a set.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned MODE_BITS = 2;
   localparam int unsigned PINS_PER_MODE_WORD = BUS_W / MODE_BITS;

   typedef enum logic [ADDR_W-1:0] {
      REG_OUT     = 4'd0,
      REG_SET     = 4'd1,
      REG_CLR     = 4'd2,
      REG_TGL     = 4'd3,
      REG_DIR     = 4'd4,
      REG_IN      = 4'd5,
      REG_FLAG    = 4'd6,
      REG_MODE_LO = 4'd7,
      REG_MODE_HI = 4'd8,
      REG_DMA     = 4'd9
   } reg_idx_e;

   typedef enum logic [MODE_BITS-1:0] {
      EVT_OFF  = 2'd0,
      EVT_RISE = 2'd1,
      EVT_FALL = 2'd2,
      EVT_HIGH = 2'd3
   } evt_mode_e;

   typedef struct packed {
      logic wr_out;
      logic wr_set;
      logic wr_clr;
      logic wr_tgl;
      logic wr_dir;
      logic wr_flag;
      logic wr_mode_lo;
      logic wr_mode_hi;
      logic wr_dma;
   } wr_dec_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_dec_t          dec,
   input  logic [WIDTH-1:0] wmask,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] dir_q
);

   logic [WIDTH-1:0] out_nxt;

   // Fixed order of application: load, set, clear, toggle.
   always_comb begin
      out_nxt = out_q;
      if (dec.wr_out) out_nxt = wmask;
      if (dec.wr_set) out_nxt = out_nxt | wmask;
      if (dec.wr_clr) out_nxt = out_nxt & ~wmask;
      if (dec.wr_tgl) out_nxt = out_nxt ^ wmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         out_q <= out_nxt;
         if (dec.wr_dir) dir_q <= wmask;
      end
   end

endmodule

// File: rtl/gpio_evt_flags.sv
module gpio_evt_flags
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WIDTH-1:0]           sync_in,
   input  logic [WIDTH*MODE_BITS-1:0] mode_cfg,
   input  logic [WIDTH-1:0]           dma_sel,
   input  logic                       sw_clr_en,
   input  logic [WIDTH-1:0]           sw_clr_mask,
   input  logic [WIDTH-1:0]           dma_done,
   output logic [WIDTH-1:0]           flags
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   generate
      for (genvar p = 0; p < WIDTH; p++) begin : g_pin
         evt_mode_e mode;
         logic      hit;
         logic      clr;

         assign mode = evt_mode_e'(mode_cfg[p*MODE_BITS +: MODE_BITS]);

         always_comb begin
            unique case (mode)
               EVT_RISE: hit = sync_in[p] & ~prev_q[p];
               EVT_FALL: hit = ~sync_in[p] & prev_q[p];
               EVT_HIGH: hit = sync_in[p];
               default:  hit = 1'b0;
            endcase
         end

         assign clr = (sw_clr_en & sw_clr_mask[p]) | (dma_sel[p] & dma_done[p]);

         // A new event outranks any clear in the same cycle.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[p] <= 1'b0;
            else        flags[p] <= hit | (flags[p] & ~clr);
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wen,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_PINS-1:0] dma_done,
   output logic [NUM_PINS-1:0] dma_req,
   output logic                evt_irq
);

   localparam int unsigned MODE_W      = NUM_PINS * MODE_BITS;
   localparam int unsigned MODE_FULL_W = 2 * BUS_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
         $error("gpio_atomic_port: NUM_PINS must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_atomic_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   wr_dec_t                 dec;
   logic [NUM_PINS-1:0]     wmask;
   logic [NUM_PINS-1:0]     in_sync;
   logic [NUM_PINS-1:0]     out_q;
   logic [NUM_PINS-1:0]     dir_q;
   logic [NUM_PINS-1:0]     dma_q;
   logic [NUM_PINS-1:0]     evt_flags;
   logic [MODE_W-1:0]       mode_q;
   logic [MODE_FULL_W-1:0]  mode_full;
   logic [MODE_FULL_W-1:0]  mode_full_nxt;

   assign wmask = bus_wdata[NUM_PINS-1:0];

   always_comb begin
      dec = '0;
      if (bus_wen) begin
         case (bus_addr)
            REG_OUT:     dec.wr_out     = 1'b1;
            REG_SET:     dec.wr_set     = 1'b1;
            REG_CLR:     dec.wr_clr     = 1'b1;
            REG_TGL:     dec.wr_tgl     = 1'b1;
            REG_DIR:     dec.wr_dir     = 1'b1;
            REG_FLAG:    dec.wr_flag    = 1'b1;
            REG_MODE_LO: dec.wr_mode_lo = 1'b1;
            REG_MODE_HI: dec.wr_mode_hi = 1'b1;
            REG_DMA:     dec.wr_dma     = 1'b1;
            default:     dec = '0;
         endcase
      end
   end

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (in_sync)
   );

   gpio_out_ctrl #(
      .WIDTH (NUM_PINS)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (dec),
      .wmask (wmask),
      .out_q (out_q),
      .dir_q (dir_q)
   );

   // Mode words: pins 0..15 in the low word, 16..31 in the high word.
   assign mode_full = MODE_FULL_W'(mode_q);

   always_comb begin
      mode_full_nxt = mode_full;
      if (dec.wr_mode_lo) mode_full_nxt[BUS_W-1:0]           = bus_wdata;
      if (dec.wr_mode_hi) mode_full_nxt[MODE_FULL_W-1:BUS_W] = bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         dma_q  <= '0;
      end else begin
         mode_q <= mode_full_nxt[MODE_W-1:0];
         if (dec.wr_dma) dma_q <= wmask;
      end
   end

   gpio_evt_flags #(
      .WIDTH (NUM_PINS)
   ) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_in     (in_sync),
      .mode_cfg    (mode_q),
      .dma_sel     (dma_q),
      .sw_clr_en   (dec.wr_flag),
      .sw_clr_mask (wmask),
      .dma_done    (dma_done),
      .flags       (evt_flags)
   );

   always_comb begin
      case (bus_addr)
         REG_OUT:     bus_rdata = BUS_W'(out_q);
         REG_DIR:     bus_rdata = BUS_W'(dir_q);
         REG_IN:      bus_rdata = BUS_W'(in_sync);
         REG_FLAG:    bus_rdata = BUS_W'(evt_flags);
         REG_MODE_LO: bus_rdata = mode_full[BUS_W-1:0];
         REG_MODE_HI: bus_rdata = mode_full[MODE_FULL_W-1:BUS_W];
         REG_DMA:     bus_rdata = BUS_W'(dma_q);
         default:     bus_rdata = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign dma_req = evt_flags & dma_q;
   assign evt_irq = |evt_flags;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wen,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BUS_W-1:0]    bus_wdata,
   input logic [BUS_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] dma_done,
   input logic [NUM_PINS-1:0] dma_req,
   input logic [NUM_PINS-1:0] flags
);

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata[NUM_PINS-1:0]))); // R1

   AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == REG_SET) |=>
      (pin_out == ($past(pin_out) | $past(bus_wdata[NUM_PINS-1:0])))); // R3

   AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == REG_CLR) |=>
      (pin_out == ($past(pin_out) & ~$past(bus_wdata[NUM_PINS-1:0])))); // R4

   AST_TGL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == REG_TGL) |=>
      (pin_out == ($past(pin_out) ^ $past(bus_wdata[NUM_PINS-1:0])))); // R5

   AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_SET || bus_addr == REG_CLR || bus_addr == REG_TGL) |-> (bus_rdata == '0)); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wen && bus_addr == REG_FLAG) && dma_done == '0) |=>
      ((flags & $past(flags)) == $past(flags))); // R9

   AST_DMA_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_req & ~flags) == '0)); // R11

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wen   (bus_wen),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .dma_done  (dma_done),
   .dma_req   (dma_req),
   .flags     (evt_flags)
);

// File: tb/gpio_atomic_port_tb.sv
module gpio_atomic_port_tb;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wen = 1'b0;
   logic [3:0]    bus_addr = 4'd0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out;
   logic [N-1:0]  pin_oe;
   logic [N-1:0]  dma_done = '0;
   logic [N-1:0]  dma_req;
   logic          evt_irq;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_atomic_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wen   (bus_wen),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .dma_done  (dma_done),
      .dma_req   (dma_req),
      .evt_irq   (evt_irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_out, m_dir, m_flag, m_dma, m_mlo, m_mhi, m_sync, m_prev;
   logic [31:0] m_pipe [$];

   function automatic int mode_of(int p);
      if (p < 16) return int'((m_mlo >> (2*p)) & 32'd3);
      return int'((m_mhi >> (2*(p-16))) & 32'd3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out = 0; m_dir = 0; m_flag = 0; m_dma = 0;
         m_mlo = 0; m_mhi = 0; m_sync = 0; m_prev = 0;
         m_pipe = {32'd0, 32'd0};
      end else begin
         logic [31:0] nf;
         nf = m_flag;
         for (int p = 0; p < N; p++) begin
            bit ev, cl;
            case (mode_of(p))
               1: ev = m_sync[p] && !m_prev[p];
               2: ev = !m_sync[p] && m_prev[p];
               3: ev = m_sync[p];
               default: ev = 0;
            endcase
            cl = (bus_wen && bus_addr == 4'd6 && bus_wdata[p]) || (m_dma[p] && dma_done[p]);
            if (ev) nf[p] = 1;
            else if (cl) nf[p] = 0;
         end
         m_flag = nf;
         if (bus_wen) begin
            case (bus_addr)
               4'd0: m_out = bus_wdata;
               4'd1: m_out = m_out | bus_wdata;
               4'd2: m_out = m_out & ~bus_wdata;
               4'd3: m_out = m_out ^ bus_wdata;
               4'd4: m_dir = bus_wdata;
               4'd7: m_mlo = bus_wdata;
               4'd8: m_mhi = bus_wdata;
               4'd9: m_dma = bus_wdata;
               default: ;
            endcase
         end
         m_prev = m_sync;
         m_pipe.push_front(pin_in);
         void'(m_pipe.pop_back());
         m_sync = m_pipe[1];
      end
   end

   function automatic logic [31:0] m_read(logic [3:0] a);
      case (a)
         4'd0: return m_out;
         4'd4: return m_dir;
         4'd5: return m_sync;
         4'd6: return m_flag;
         4'd7: return m_mlo;
         4'd8: return m_mhi;
         4'd9: return m_dma;
         default: return 0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare against the model on every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R2 pin_out", pin_out, m_out);
         check("R1 pin_oe", pin_oe, m_dir);
         check("R9 evt_irq", {31'd0, evt_irq}, {31'd0, m_flag != 0});
         check("R11 dma_req", dma_req, m_flag & m_dma);
         check((bus_addr inside {4'd1, 4'd2, 4'd3}) ? "R6 rdata" : "R7 rdata",
               bus_rdata, m_read(bus_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) begin
         @(posedge clk);
         #5;
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      tick(1);
      bus_wen = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_check(string tag, logic [3:0] a, logic [31:0] exp);
      bus_addr = a;
      #4;
      check(tag, bus_rdata, exp);
   endtask

   initial begin
      #(200000 * 20);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1: reset state
      check("R1 reset oe", pin_oe, 32'h0);
      check("R1 reset out", pin_out, 32'h0);
      for (int a = 0; a < 16; a++) rd_check("R1 reset read", 4'(a), 32'h0);

      wr(4'd4, 32'hFFFF_0000);
      check("R1 dir", pin_oe, 32'hFFFF_0000);
      wr(4'd0, 32'h1234_5678);
      check("R2 load", pin_out, 32'h1234_5678);
      wr(4'd1, 32'h0000_00FF);
      check("R3 set", pin_out, 32'h1234_56FF);
      wr(4'd2, 32'h1230_0000);
      check("R4 clear", pin_out, 32'h0004_56FF);
      wr(4'd3, 32'hFFFF_0000);
      check("R5 toggle", pin_out, 32'hFFFB_56FF);
      rd_check("R6 set reads 0", 4'd1, 32'h0);
      rd_check("R6 clr reads 0", 4'd2, 32'h0);
      rd_check("R6 tgl reads 0", 4'd3, 32'h0);

      // R7: two-flop latency to the input register
      pin_in = 32'hA5A5_0000;
      tick(1);
      rd_check("R7 not yet", 4'd5, 32'h0);
      tick(1);
      rd_check("R7 visible", 4'd5, 32'hA5A5_0000);
      pin_in = '0;
      tick(4);

      // R8: pin0 rising, pin1 falling, pin2 high, pin17 rising
      wr(4'd7, 32'h0000_0039);
      wr(4'd8, 32'h0000_0004);
      rd_check("R8 mode lo", 4'd7, 32'h0000_0039);
      pin_in = 32'h0002_0001;
      tick(2);
      rd_check("R8 not yet", 4'd6, 32'h0);
      tick(1);
      rd_check("R8 rise flags", 4'd6, 32'h0002_0001);

      // R9: write-one clears, write-zero ignored
      wr(4'd6, 32'h0000_0001);
      rd_check("R9 w1c", 4'd6, 32'h0002_0000);
      wr(4'd6, 32'h0);
      rd_check("R9 w0 ignored", 4'd6, 32'h0002_0000);
      check("R9 irq", {31'd0, evt_irq}, 32'd1);

      // R10: level stays active through a clear
      pin_in = 32'h0002_0005;
      tick(3);
      rd_check("R10 level set", 4'd6, 32'h0002_0004);
      wr(4'd6, 32'h0000_0004);
      rd_check("R10 level resets", 4'd6, 32'h0002_0004);
      pin_in = 32'h0002_0001;
      tick(3);
      wr(4'd6, 32'h0000_0004);
      rd_check("R10 level gone", 4'd6, 32'h0002_0000);

      // R8: falling edge on pin1
      pin_in = 32'h0002_0003;
      tick(4);
      pin_in = 32'h0002_0001;
      tick(3);
      rd_check("R8 fall flag", 4'd6, 32'h0002_0002);

      // R11: DMA routing for pin1 only
      wr(4'd9, 32'h0000_0002);
      check("R11 req", dma_req, 32'h0000_0002);
      dma_done = 32'h0002_0000;
      tick(1);
      dma_done = '0;
      rd_check("R11 unselected done ignored", 4'd6, 32'h0002_0002);
      dma_done = 32'h0000_0002;
      tick(1);
      dma_done = '0;
      rd_check("R11 done clears", 4'd6, 32'h0002_0000);
      check("R11 req gone", dma_req, 32'h0);

      // R12: set beats a simultaneous DMA clear on pin0
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd9, 32'h0000_0003);
      pin_in = 32'h0;
      tick(4);
      pin_in = 32'h0000_0001;
      tick(2);
      dma_done = 32'h0000_0001;
      tick(1);
      dma_done = '0;
      rd_check("R12 set wins", 4'd6, 32'h0000_0001);
      check("R12 req", dma_req, 32'h0000_0001);
      dma_done = 32'h0000_0001;
      tick(1);
      dma_done = '0;
      rd_check("R11 later done clears", 4'd6, 32'h0);

      // R12: set beats a simultaneous write-one clear on pin17
      pin_in = 32'h0;
      tick(4);
      pin_in = 32'h0002_0000;
      tick(2);
      bus_wen = 1'b1; bus_addr = 4'd6; bus_wdata = 32'h0002_0000;
      tick(1);
      bus_wen = 1'b0; bus_wdata = '0;
      rd_check("R12 set beats w1c", 4'd6, 32'h0002_0000);

      tick(2);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule